// File: doc/BRIEF.md
# EEPROM Status Register and Write Guard

This block keeps the status register of a serial EEPROM controller and rules on every write that the command decoder presents to it. The decoder hands it single-cycle event pulses: a write-enable command, a write-disable command, a status-write request with its data byte, and an array-write request with its target address. A separate pulse tells it that the self-timed programming cycle has finished. For each request the block answers in the same clock cycle with either a grant or a deny. A grant is the start signal for the programming sequencer. A deny means no cycle is started.

The block holds four things: the write-enable latch, the busy flag, a two-bit fence that guards the upper quarter, the upper half or the whole array, and a lock bit. When the lock bit is set and the active-low protect pin is low, the status register is frozen. The packed status byte is always on the output, so a status read may take place at any moment, including during a programming cycle.

All inputs are plain control pulses with no back-pressure, because the block accepts or refuses every request in the cycle it arrives. The caller must not hold a request for longer than one cycle. The power-on reset is active low and asynchronous.

Top module: `eeprom_guard`

## Requirements
- R1: After reset the status byte is 00h, busy is 0 and all four grant/deny outputs are 0.
- R2: When idle and with no write request in the same cycle, a write-enable pulse sets the enable latch and a write-disable pulse clears it. Both take effect at the next clock edge.
- R3: The status byte layout is: bit 0 busy, bit 1 enable latch, bits 3:2 fence, bit 7 lock, and bits 6:4 read as 0. It reflects the current state in every cycle, including while busy.
- R4: An array-write request is granted in its own cycle only if the enable latch is 1, the block is idle, no status-write request is present and the address is outside the fenced region. Otherwise it is denied in that cycle.
- R5: The fence encodings, for an address width W, are:
  - 00 protects nothing.
  - 01 protects the addresses whose top two bits are both 1 (the upper quarter).
  - 10 protects the addresses whose top bit is 1 (the upper half).
  - 11 protects every address.
- R6: A status-write request is granted only if the enable latch is 1, the block is idle and the pair (lock = 1, protect pin = 0) does not hold. On a grant, the fence is loaded from data bits 3:2 and the lock from data bit 7 at the next edge. Data bits 6:4 and 1:0 are ignored.
- R7: A grant sets busy at the next edge. Busy then holds until a cycle-done pulse arrives, and the edge after that pulse clears both busy and the enable latch.
- R8: A denied request leaves busy, the enable latch, the fence and the lock unchanged.
- R9: While busy, write-enable, write-disable and both kinds of write request have no effect on the state, and every write request is denied.
- R10: A cycle-done pulse while idle has no effect.
- R11: When a status-write request and an array-write request arrive together, only the status write is considered and the array write is denied. When write-enable and write-disable arrive together, the disable wins. A write-enable or write-disable that arrives together with any write request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| ev_arm | input | 1 | Write-enable command pulse |
| ev_disarm | input | 1 | Write-disable command pulse |
| ev_st_wr | input | 1 | Status-write request pulse |
| st_wr_data | input | 8 | Data byte of the status-write request |
| ev_arr_wr | input | 1 | Array-write request pulse |
| arr_wr_addr | input | ADDR_W | Target address of the array-write request |
| cycle_done | input | 1 | Programming cycle finished |
| wprot_n | input | 1 | Active-low write-protect pin |
| status_byte | output | 8 | Packed status register |
| busy | output | 1 | Programming cycle in progress |
| st_wr_grant | output | 1 | Status write accepted, start cycle |
| st_wr_deny | output | 1 | Status write refused |
| arr_wr_grant | output | 1 | Array write accepted, start cycle |
| arr_wr_deny | output | 1 | Array write refused |

## Verification
The bench builds the block with ADDR_W = 6, which gives a 64-entry address space. Every address can then be tried against all four fence settings, with the expected verdict computed from the address value alone. That sweep covers the exact boundaries between the quarter and half regions. It also covers every combination of enable latch, lock bit and protect pin for status writes, each request kind while busy, and the simultaneous-event priorities.

// File: rtl/eeprom_guard_pkg.sv
package eeprom_guard_pkg;

  typedef enum logic [1:0] {
    FENCE_NONE    = 2'b00,
    FENCE_QUARTER = 2'b01,
    FENCE_HALF    = 2'b10,
    FENCE_ALL     = 2'b11
  } fence_e;

  localparam int ST_BUSY_BIT  = 0;
  localparam int ST_LATCH_BIT = 1;
  localparam int ST_FENCE_LO  = 2;
  localparam int ST_FENCE_HI  = 3;
  localparam int ST_LOCK_BIT  = 7;

  function automatic logic [7:0] st_pack(input logic busy_i, input logic latch_i,
                                         input fence_e fence_i, input logic lock_i);
    logic [7:0] b;
    b = 8'h00;
    b[ST_BUSY_BIT]               = busy_i;
    b[ST_LATCH_BIT]              = latch_i;
    b[ST_FENCE_HI:ST_FENCE_LO]   = fence_i;
    b[ST_LOCK_BIT]               = lock_i;
    return b;
  endfunction

endpackage

// File: rtl/eeprom_guard_fence.sv
module eeprom_guard_fence
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  fence_e              fence,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit
);
  localparam int TOP = ADDR_W - 1;

  logic in_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_quarter = addr[TOP] & addr[TOP-1];
    end else begin : g_narrow
      assign in_quarter = addr[TOP];
    end
  endgenerate

  always_comb begin
    unique case (fence)
      FENCE_NONE:    hit = 1'b0;
      FENCE_QUARTER: hit = in_quarter;
      FENCE_HALF:    hit = addr[TOP];
      default:       hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/eeprom_guard_judge.sv
module eeprom_guard_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_st_wr,
  input  logic ev_arr_wr,
  input  logic latch,
  input  logic busy,
  input  logic lock,
  input  logic wprot_n,
  input  logic fence_hit,
  output logic st_wr_grant,
  output logic st_wr_deny,
  output logic arr_wr_grant,
  output logic arr_wr_deny
);
  logic armed_idle;
  logic st_ok;
  logic arr_ok;

  assign armed_idle = latch & ~busy;
  assign st_ok      = armed_idle & ~(lock & ~wprot_n);
  assign arr_ok     = armed_idle & ~fence_hit & ~ev_st_wr;

  assign st_wr_grant  = ev_st_wr  & st_ok;
  assign st_wr_deny   = ev_st_wr  & ~st_ok;
  assign arr_wr_grant = ev_arr_wr & arr_ok;
  assign arr_wr_deny  = ev_arr_wr & ~arr_ok;

  assert_grant_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_grant || arr_wr_grant) |-> (latch && !busy));

  assert_lock_pin_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_grant |-> !(lock && !wprot_n));

  assert_single_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_wr_grant, arr_wr_grant}));

  assert_busy_denies_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_arr_wr) |-> arr_wr_deny);
endmodule

// File: rtl/eeprom_guard_state.sv
module eeprom_guard_state
  import eeprom_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_arm,
  input  logic       ev_disarm,
  input  logic       req_any,
  input  logic       st_wr_grant,
  input  logic       arr_wr_grant,
  input  logic [7:0] st_wr_data,
  input  logic       cycle_done,
  output logic       busy,
  output logic       latch,
  output fence_e     fence,
  output logic       lock
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      latch <= 1'b0;
      fence <= FENCE_NONE;
      lock  <= 1'b0;
    end else if (busy) begin
      if (cycle_done) begin
        busy  <= 1'b0;
        latch <= 1'b0;
      end
    end else if (st_wr_grant) begin
      busy  <= 1'b1;
      fence <= fence_e'(st_wr_data[ST_FENCE_HI:ST_FENCE_LO]);
      lock  <= st_wr_data[ST_LOCK_BIT];
    end else if (arr_wr_grant) begin
      busy <= 1'b1;
    end else if (!req_any) begin
      if (ev_disarm)   latch <= 1'b0;
      else if (ev_arm) latch <= 1'b1;
    end
  end

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cycle_done) |=> (!busy && !latch));

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cycle_done) |=> busy);

  assert_busy_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(fence) && $stable(lock)));

  assert_arm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ev_arm && !ev_disarm && !req_any) |=> latch);

  assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cycle_done && !req_any && !ev_arm && !ev_disarm) |=> ($stable(latch) && !busy));
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_arm,
  input  logic              ev_disarm,
  input  logic              ev_st_wr,
  input  logic [7:0]        st_wr_data,
  input  logic              ev_arr_wr,
  input  logic [ADDR_W-1:0] arr_wr_addr,
  input  logic              cycle_done,
  input  logic              wprot_n,
  output logic [7:0]        status_byte,
  output logic              busy,
  output logic              st_wr_grant,
  output logic              st_wr_deny,
  output logic              arr_wr_grant,
  output logic              arr_wr_deny
);
  logic   latch;
  logic   lock;
  fence_e fence;
  logic   fence_hit;
  logic   unused_data_bits;

  assign unused_data_bits = ^{st_wr_data[6:4], st_wr_data[1:0]};

  eeprom_guard_fence #(.ADDR_W(ADDR_W)) fence_i (
    .fence (fence),
    .addr  (arr_wr_addr),
    .hit   (fence_hit)
  );

  eeprom_guard_judge judge_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_st_wr     (ev_st_wr),
    .ev_arr_wr    (ev_arr_wr),
    .latch        (latch),
    .busy         (busy),
    .lock         (lock),
    .wprot_n      (wprot_n),
    .fence_hit    (fence_hit),
    .st_wr_grant  (st_wr_grant),
    .st_wr_deny   (st_wr_deny),
    .arr_wr_grant (arr_wr_grant),
    .arr_wr_deny  (arr_wr_deny)
  );

  eeprom_guard_state state_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_arm       (ev_arm),
    .ev_disarm    (ev_disarm),
    .req_any      (ev_st_wr | ev_arr_wr),
    .st_wr_grant  (st_wr_grant),
    .arr_wr_grant (arr_wr_grant),
    .st_wr_data   (st_wr_data),
    .cycle_done   (cycle_done),
    .busy         (busy),
    .latch        (latch),
    .fence        (fence),
    .lock         (lock)
  );

  assign status_byte = st_pack(busy, latch, fence, lock);

  assert_grant_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_grant || arr_wr_grant) |=> busy);

  assert_deny_no_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (st_wr_deny || arr_wr_deny) && !st_wr_grant && !arr_wr_grant) |=> !busy);

  assert_fenced_denied_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arr_wr && fence == FENCE_ALL) |-> arr_wr_deny);

  assert_spare_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:4] == 3'b000);
endmodule

// File: tb/eeprom_guard_tb_top.sv
module eeprom_guard_tb_top;
  localparam int AW = 6;
  localparam int NADDR = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_arm = 0, ev_disarm = 0, ev_st_wr = 0, ev_arr_wr = 0, cycle_done = 0;
  logic wprot_n = 1'b1;
  logic [7:0] st_wr_data = 8'h00;
  logic [AW-1:0] arr_wr_addr = '0;
  logic [7:0] status_byte;
  logic busy, st_wr_grant, st_wr_deny, arr_wr_grant, arr_wr_deny;

  logic g_st, d_st, g_ar, d_ar;
  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  eeprom_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_arm(ev_arm), .ev_disarm(ev_disarm),
    .ev_st_wr(ev_st_wr), .st_wr_data(st_wr_data), .ev_arr_wr(ev_arr_wr),
    .arr_wr_addr(arr_wr_addr), .cycle_done(cycle_done), .wprot_n(wprot_n),
    .status_byte(status_byte), .busy(busy), .st_wr_grant(st_wr_grant),
    .st_wr_deny(st_wr_deny), .arr_wr_grant(arr_wr_grant), .arr_wr_deny(arr_wr_deny)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One event cycle: drive at negedge, capture verdicts mid-cycle,
  // release at the next negedge (state after the edge is then visible).
  task automatic step(input logic a, input logic d, input logic s, input logic w,
                      input logic c, input logic [7:0] dat, input logic [AW-1:0] adr);
    @(negedge clk);
    ev_arm = a; ev_disarm = d; ev_st_wr = s; ev_arr_wr = w; cycle_done = c;
    st_wr_data = dat; arr_wr_addr = adr;
    #1;
    g_st = st_wr_grant; d_st = st_wr_deny; g_ar = arr_wr_grant; d_ar = arr_wr_deny;
    @(negedge clk);
    ev_arm = 0; ev_disarm = 0; ev_st_wr = 0; ev_arr_wr = 0; cycle_done = 0;
  endtask

  task automatic arm();    step(1,0,0,0,0,8'h00,'0); endtask
  task automatic disarm(); step(0,1,0,0,0,8'h00,'0); endtask
  task automatic finish_cycle(); step(0,0,0,0,1,8'h00,'0); endtask

  function automatic logic [7:0] st_exp(input logic b, input logic l,
                                        input logic [1:0] f, input logic k);
    return {k, 3'b000, f, l, b};
  endfunction

  function automatic logic fenced(input logic [1:0] f, input int a);
    case (f)
      2'd0: return 1'b0;
      2'd1: return a >= (NADDR * 3) / 4;
      2'd2: return a >= NADDR / 2;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset status", status_byte, 8'h00);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset verdicts", {st_wr_grant, st_wr_deny, arr_wr_grant, arr_wr_deny}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: arm / disarm
    arm();    chk("R2 arm sets latch", status_byte, 8'h02);
    disarm(); chk("R2 disarm clears latch", status_byte, 8'h00);

    // R4/R8: write without latch is denied and changes nothing
    step(0,0,0,1,0,8'h00,6'd0);
    chk("R4 unarmed write denied", {g_ar, d_ar}, 2'b01);
    chk("R8 denied write state kept", status_byte, 8'h00);

    // R4/R5: exhaustive fence x address sweep
    for (int f = 0; f < 4; f++) begin
      arm();
      step(0,0,1,0,0,8'(f << 2),'0);
      chk("R6 fence load grant", {g_st, d_st}, 2'b10);
      chk("R3 status during status cycle", status_byte, st_exp(1,1,2'(f),0));
      finish_cycle();
      chk("R7 status cycle end", status_byte, st_exp(0,0,2'(f),0));
      for (int a = 0; a < NADDR; a++) begin
        logic prot;
        prot = fenced(2'(f), a);
        arm();
        step(0,0,0,1,0,8'h00,AW'(a));
        chk($sformatf("R5 fence=%0d addr=%0d verdict", f, a), {g_ar, d_ar}, prot ? 2'b01 : 2'b10);
        if (prot) begin
          chk("R8 fenced write keeps latch", status_byte, st_exp(0,1,2'(f),0));
          disarm();
        end else begin
          chk("R7 write busy", status_byte, st_exp(1,1,2'(f),0));
          finish_cycle();
          chk("R7 write done clears", status_byte, st_exp(0,0,2'(f),0));
        end
      end
    end

    // R6: ignored data bits, lock loaded
    arm();
    step(0,0,1,0,0,8'hFF,'0);
    chk("R6 full byte grant", {g_st, d_st}, 2'b10);
    chk("R3 status 8F while busy", status_byte, 8'h8F);
    finish_cycle();
    chk("R6 spare data bits ignored", status_byte, 8'h8C);

    // R6/R8: lock with pin low blocks, pin high allows
    wprot_n = 1'b0;
    arm();
    step(0,0,1,0,0,8'h00,'0);
    chk("R6 locked pin low denied", {g_st, d_st}, 2'b01);
    chk("R8 locked deny state kept", status_byte, 8'h8E);
    disarm();
    wprot_n = 1'b1;
    arm();
    step(0,0,1,0,0,8'h00,'0);
    chk("R6 locked pin high granted", {g_st, d_st}, 2'b10);
    finish_cycle();
    chk("R6 lock cleared", status_byte, 8'h00);
    // unlocked: pin low has no effect
    wprot_n = 1'b0;
    arm();
    step(0,0,1,0,0,8'h04,'0);
    chk("R6 unlocked pin low granted", {g_st, d_st}, 2'b10);
    finish_cycle();
    chk("R6 unlocked load", status_byte, 8'h04);
    arm();
    step(0,0,1,0,0,8'h00,'0);
    finish_cycle();
    wprot_n = 1'b1;
    chk("R6 fence back to none", status_byte, 8'h00);

    // R9: events while busy
    arm();
    step(0,0,0,1,0,8'h00,6'd1);
    chk("R9 setup grant", {g_ar, d_ar}, 2'b10);
    disarm();
    chk("R9 disarm ignored while busy", status_byte, 8'h03);
    step(0,0,0,1,0,8'h00,6'd2);
    chk("R9 write denied while busy", {g_ar, d_ar}, 2'b01);
    step(0,0,1,0,0,8'h8C,'0);
    chk("R9 status write denied while busy", {g_st, d_st}, 2'b01);
    chk("R9 state frozen while busy", status_byte, 8'h03);
    repeat (5) @(negedge clk);
    chk("R7 busy holds without done", busy, 1);
    finish_cycle();
    chk("R7 done ends cycle", status_byte, 8'h00);

    // R10: done while idle
    arm();
    finish_cycle();
    chk("R10 idle done ignored", status_byte, 8'h02);

    // R11: priorities
    step(0,0,1,1,0,8'h08,6'd0);
    chk("R11 status write wins", {g_st, d_st}, 2'b10);
    chk("R11 array write denied", {g_ar, d_ar}, 2'b01);
    finish_cycle();
    chk("R11 status write applied", status_byte, 8'h08);
    step(1,1,0,0,0,8'h00,'0);
    chk("R11 disarm beats arm", status_byte, 8'h08);
    arm();
    step(1,1,0,0,0,8'h00,'0);
    chk("R11 disarm beats arm from set", status_byte, 8'h08);
    step(1,0,0,1,0,8'h00,6'd0);
    chk("R11 arm with write: denied", {g_ar, d_ar}, 2'b01);
    chk("R11 arm with write ignored", status_byte, 8'h08);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule